// File: doc/BRIEF.md
# VLIW5 Issue Bundle Packer

This block sits between an in-order decoder and a five-lane VLIW arithmetic cluster. It accepts decoded scalar operations one at a time over a valid/ready handshake and assembles them into wide issue bundles. Each bundle has five ALU lanes and one separate branch slot. Every lane has its own valid bit. The lanes are not interchangeable. The highest lane is the only one that can run transcendental functions. A four-wide dot product takes the four low lanes as a group. Plain arithmetic fills the low lanes first and falls back to the top lane only when it must.

The packer keeps one bundle open. An incoming operation is added to it when a legal lane is free and none of its sources is produced by an operation already in the bundle. Otherwise the open bundle is sent out on its own, and the operation starts a fresh bundle on the following cycle. A branch always ends the bundle it joins. A bundle whose five lanes are all filled leaves at once. A flush pulse pushes out whatever partial bundle is open. Operations are never reordered: they leave in bundles in exactly the order they arrived.

Top module: `vliw_bundle_packer`

## Requirements
- R1: After reset no bundle is offered, and every lane valid bit and the branch valid bit read 0.
- R2: Operation class codes 0, 1, 2, 3 and 7 (float multiply-add, float add, float multiply, integer add, reserved) are plain arithmetic. Each takes the lowest free lane among lanes 0 to 3. It takes lane 4 only when lanes 0 to 3 are all occupied.
- R3: Class 4 (transcendental) may only occupy lane 4. If lane 4 is already taken in the open bundle, that bundle is closed first.
- R4: Class 5 (dot product) occupies lanes 0 to 3 together, and each of those lanes carries the same operation fields. It needs all four lanes free; otherwise the open bundle is closed first.
- R5: Class 6 (branch) goes to the branch slot, carrying its two sources and its target field. The bundle it joins is emitted on the same clock edge that accepts it, so two branches never share a bundle.
- R6: An operation whose source A or source B equals the destination of a valid lane in the open bundle is not placed there. The open bundle is emitted without it, and the operation leads the next bundle.
- R7: A bundle whose five lanes are all valid is emitted on the edge that accepts its last operation.
- R8: A flush pulse emits a non-empty open bundle on the next clock edge if the output is free, with unused lanes marked invalid. With an empty open bundle, a flush produces nothing.
- R9: Every accepted operation appears exactly once in the output, in input order, with lane fields cleared to zero wherever the lane valid bit is 0.
- R10: While a bundle is offered and not taken, the whole bundle output is held stable and is not overwritten.
- R11: When an operation forces the open bundle closed (R3, R4, R6), the operation is not accepted on that edge: op_ready stays low while the open bundle is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Request to emit the open partial bundle |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation accepted this cycle |
| op_cls | input | 3 | Operation class code |
| op_src_a | input | REG_W | First source register index |
| op_src_b | input | REG_W | Second source register index |
| op_dst | input | REG_W | Destination register index (branch target for class 6) |
| bnd_valid | output | 1 | Bundle offered |
| bnd_ready | input | 1 | Consumer takes the bundle |
| bnd_lane_vld | output | LANES | Per-lane valid bits |
| bnd_lane_cls | output | 3*LANES | Per-lane class, lane i at bits 3i+2..3i |
| bnd_lane_src_a | output | REG_W*LANES | Per-lane first source |
| bnd_lane_src_b | output | REG_W*LANES | Per-lane second source |
| bnd_lane_dst | output | REG_W*LANES | Per-lane destination |
| bnd_br_vld | output | 1 | Branch slot valid |
| bnd_br_src_a | output | REG_W | Branch first source |
| bnd_br_src_b | output | REG_W | Branch second source |
| bnd_br_tgt | output | REG_W | Branch target field |

## Verification
The assertions assume that an offered operation carries one of the eight defined class codes. They also assume the consumer follows the handshake, so a held bundle is only released by bnd_ready. The stimulus draws classes only from the defined codes and uses a small register range so that dependences are frequent. Flush pulses are raised only while no operation is being offered, and the consumer ready is randomized independently of the producer.

// File: rtl/vp_pkg.sv
package vp_pkg;

   typedef enum logic [2:0] {
      CLS_FMAD   = 3'd0,
      CLS_FADD   = 3'd1,
      CLS_FMUL   = 3'd2,
      CLS_IADD   = 3'd3,
      CLS_TRANS  = 3'd4,
      CLS_DOT    = 3'd5,
      CLS_BRANCH = 3'd6,
      CLS_RSVD   = 3'd7
   } op_cls_e;

   localparam int CLS_W = 3;

   function automatic logic cls_is_branch(input logic [CLS_W-1:0] c);
      return op_cls_e'(c) == CLS_BRANCH;
   endfunction

endpackage

// File: rtl/vp_lane_alloc.sv
module vp_lane_alloc
   import vp_pkg::*;
#(
   parameter int LANES = 5,
   parameter int DOT_W = 4
) (
   input  logic [LANES-1:0] occ,
   input  logic [CLS_W-1:0] cls,
   output logic             fits,
   output logic [LANES-1:0] place
);

   localparam int LOW = LANES - 1;
   localparam int TOP = LANES - 1;
   localparam logic [LANES-1:0] DOT_MASK = LANES'((1 << DOT_W) - 1);

   logic [LOW-1:0] low_pick;
   logic [LOW:0]   seen_free;

   assign seen_free[0] = 1'b0;

   generate
      for (genvar i = 0; i < LOW; i++) begin : g_pick
         assign low_pick[i]    = ~occ[i] & ~seen_free[i];
         assign seen_free[i+1] = seen_free[i] | ~occ[i];
      end
   endgenerate

   always_comb begin
      place = '0;
      fits  = 1'b0;
      case (op_cls_e'(cls))
         CLS_BRANCH: begin
            fits = 1'b1;
         end
         CLS_TRANS: begin
            if (!occ[TOP]) begin
               place[TOP] = 1'b1;
               fits       = 1'b1;
            end
         end
         CLS_DOT: begin
            if ((occ & DOT_MASK) == '0) begin
               place = DOT_MASK;
               fits  = 1'b1;
            end
         end
         default: begin
            if (|low_pick) begin
               place[LOW-1:0] = low_pick;
               fits           = 1'b1;
            end else if (!occ[TOP]) begin
               place[TOP] = 1'b1;
               fits       = 1'b1;
            end
         end
      endcase
   end

endmodule

// File: rtl/vp_dep_check.sv
module vp_dep_check #(
   parameter int LANES = 5,
   parameter int REG_W = 6
) (
   input  logic [LANES-1:0]            vld,
   input  logic [LANES-1:0][REG_W-1:0] dst,
   input  logic [REG_W-1:0]            src_a,
   input  logic [REG_W-1:0]            src_b,
   output logic                        hit
);

   logic [LANES-1:0] lane_hit;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_cmp
         assign lane_hit[i] = vld[i] & ((dst[i] == src_a) | (dst[i] == src_b));
      end
   endgenerate

   assign hit = |lane_hit;

endmodule

// File: rtl/vp_bundle_reg.sv
module vp_bundle_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   input  logic         ready,
   output logic         valid,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         q     <= '0;
      end else if (load) begin
         valid <= 1'b1;
         q     <= d;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end

   AST_BND_HOLD: assert property (@(posedge clk) disable iff (!rst_n) valid && !ready |=> valid && $stable(q)); // R10
   AST_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n) load |-> (!valid || ready)); // R10

endmodule

// File: rtl/vliw_bundle_packer.sv
module vliw_bundle_packer
   import vp_pkg::*;
#(
   parameter int LANES = 5,
   parameter int DOT_W = 4,
   parameter int REG_W = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     op_valid,
   output logic                     op_ready,
   input  logic [2:0]               op_cls,
   input  logic [REG_W-1:0]         op_src_a,
   input  logic [REG_W-1:0]         op_src_b,
   input  logic [REG_W-1:0]         op_dst,
   output logic                     bnd_valid,
   input  logic                     bnd_ready,
   output logic [LANES-1:0]         bnd_lane_vld,
   output logic [3*LANES-1:0]       bnd_lane_cls,
   output logic [REG_W*LANES-1:0]   bnd_lane_src_a,
   output logic [REG_W*LANES-1:0]   bnd_lane_src_b,
   output logic [REG_W*LANES-1:0]   bnd_lane_dst,
   output logic                     bnd_br_vld,
   output logic [REG_W-1:0]         bnd_br_src_a,
   output logic [REG_W-1:0]         bnd_br_src_b,
   output logic [REG_W-1:0]         bnd_br_tgt
);

   localparam int TOP   = LANES - 1;
   localparam int LANEW = 1 + CLS_W + 3 * REG_W;
   localparam int PW    = LANES * LANEW + 1 + 3 * REG_W;

   generate
      if (LANES < 2) begin : g_bad_lanes
         $error("vliw_bundle_packer: LANES must be at least 2");
      end
      if (DOT_W < 1 || DOT_W > LANES - 1) begin : g_bad_dot
         $error("vliw_bundle_packer: DOT_W must fit below the top lane");
      end
      if (REG_W < 1) begin : g_bad_reg
         $error("vliw_bundle_packer: REG_W must be positive");
      end
   endgenerate

   // open bundle
   logic [LANES-1:0]            opn_vld;
   logic [LANES-1:0][CLS_W-1:0] opn_cls;
   logic [LANES-1:0][REG_W-1:0] opn_a;
   logic [LANES-1:0][REG_W-1:0] opn_b;
   logic [LANES-1:0][REG_W-1:0] opn_dst;
   logic                        flush_pend;

   // open bundle with the offered operation merged in
   logic [LANES-1:0]            mrg_vld;
   logic [LANES-1:0][CLS_W-1:0] mrg_cls;
   logic [LANES-1:0][REG_W-1:0] mrg_a;
   logic [LANES-1:0][REG_W-1:0] mrg_b;
   logic [LANES-1:0][REG_W-1:0] mrg_dst;

   logic             lane_fits;
   logic [LANES-1:0] lane_place;
   logic             dep_hit;
   logic             is_br;
   logic             open_any;
   logic             emit_ok;
   logic             flush_req;
   logic             take_op;
   logic             emit;
   logic             emit_mrg;
   logic             flush_pend_d;
   logic [PW-1:0]    emit_word;
   logic [PW-1:0]    bnd_q;
   logic             bnd_valid_w;

   vp_lane_alloc #(
      .LANES (LANES),
      .DOT_W (DOT_W)
   ) u_alloc (
      .occ   (opn_vld),
      .cls   (op_cls),
      .fits  (lane_fits),
      .place (lane_place)
   );

   vp_dep_check #(
      .LANES (LANES),
      .REG_W (REG_W)
   ) u_dep (
      .vld   (opn_vld),
      .dst   (opn_dst),
      .src_a (op_src_a),
      .src_b (op_src_b),
      .hit   (dep_hit)
   );

   assign is_br     = cls_is_branch(op_cls);
   assign open_any  = |opn_vld;
   assign emit_ok   = ~bnd_valid_w | bnd_ready;
   assign flush_req = flush | flush_pend;

   always_comb begin
      mrg_vld = opn_vld | lane_place;
      for (int i = 0; i < LANES; i++) begin
         mrg_cls[i] = lane_place[i] ? op_cls   : opn_cls[i];
         mrg_a[i]   = lane_place[i] ? op_src_a : opn_a[i];
         mrg_b[i]   = lane_place[i] ? op_src_b : opn_b[i];
         mrg_dst[i] = lane_place[i] ? op_dst   : opn_dst[i];
      end
   end

   // sequencing: flush first, then the offered operation
   always_comb begin
      take_op      = 1'b0;
      emit         = 1'b0;
      emit_mrg     = 1'b0;
      flush_pend_d = 1'b0;
      if (flush_req) begin
         if (open_any) begin
            if (emit_ok) emit = 1'b1;
            else         flush_pend_d = 1'b1;
         end
      end else if (op_valid) begin
         if ((dep_hit || !lane_fits) && open_any) begin
            emit = emit_ok;
         end else if (is_br || (&mrg_vld)) begin
            if (emit_ok) begin
               take_op  = 1'b1;
               emit     = 1'b1;
               emit_mrg = 1'b1;
            end
         end else begin
            take_op = 1'b1;
         end
      end
   end

   assign op_ready = take_op;

   always_comb begin
      if (emit_mrg) begin
         emit_word = {mrg_vld, mrg_cls, mrg_a, mrg_b, mrg_dst,
                      is_br,
                      is_br ? op_src_a : {REG_W{1'b0}},
                      is_br ? op_src_b : {REG_W{1'b0}},
                      is_br ? op_dst   : {REG_W{1'b0}}};
      end else begin
         emit_word = {opn_vld, opn_cls, opn_a, opn_b, opn_dst,
                      1'b0, {REG_W{1'b0}}, {REG_W{1'b0}}, {REG_W{1'b0}}};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         opn_vld    <= '0;
         opn_cls    <= '0;
         opn_a      <= '0;
         opn_b      <= '0;
         opn_dst    <= '0;
         flush_pend <= 1'b0;
      end else begin
         flush_pend <= flush_pend_d;
         if (emit) begin
            opn_vld <= '0;
            opn_cls <= '0;
            opn_a   <= '0;
            opn_b   <= '0;
            opn_dst <= '0;
         end else if (take_op) begin
            opn_vld <= mrg_vld;
            opn_cls <= mrg_cls;
            opn_a   <= mrg_a;
            opn_b   <= mrg_b;
            opn_dst <= mrg_dst;
         end
      end
   end

   vp_bundle_reg #(
      .W (PW)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (emit),
      .d     (emit_word),
      .ready (bnd_ready),
      .valid (bnd_valid_w),
      .q     (bnd_q)
   );

   assign bnd_valid = bnd_valid_w;
   assign {bnd_lane_vld, bnd_lane_cls, bnd_lane_src_a, bnd_lane_src_b, bnd_lane_dst,
           bnd_br_vld, bnd_br_src_a, bnd_br_src_b, bnd_br_tgt} = bnd_q;

   // lane legality on the output side
   generate
      for (genvar i = 0; i < TOP; i++) begin : g_lane_chk
         AST_TRANS_LANE: assert property (@(posedge clk) disable iff (!rst_n) bnd_valid && bnd_lane_vld[i] |-> op_cls_e'(bnd_lane_cls[3*i +: 3]) != CLS_TRANS); // R3
         AST_BR_NODEP: assert property (@(posedge clk) disable iff (!rst_n) bnd_valid && bnd_br_vld && bnd_lane_vld[i] |-> (bnd_lane_dst[REG_W*i +: REG_W] != bnd_br_src_a) && (bnd_lane_dst[REG_W*i +: REG_W] != bnd_br_src_b)); // R6
      end
      for (genvar i = 0; i < DOT_W; i++) begin : g_dot_chk
         AST_DOT_GROUP: assert property (@(posedge clk) disable iff (!rst_n) bnd_valid && bnd_lane_vld[i] && op_cls_e'(bnd_lane_cls[3*i +: 3]) == CLS_DOT |-> &bnd_lane_vld[DOT_W-1:0]); // R4
      end
   endgenerate

   AST_TOP_LAST: assert property (@(posedge clk) disable iff (!rst_n) bnd_valid && bnd_lane_vld[TOP] && op_cls_e'(bnd_lane_cls[3*TOP +: 3]) != CLS_TRANS |-> &bnd_lane_vld[TOP-1:0]); // R2
   AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n) op_valid && op_ready && op_cls_e'(op_cls) != CLS_DOT |-> $onehot0(lane_place)); // R2
   AST_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) bnd_valid |-> (|bnd_lane_vld) || bnd_br_vld); // R8
   AST_FLUSH_OUT: assert property (@(posedge clk) disable iff (!rst_n) flush && open_any && emit_ok |=> bnd_valid); // R8
   AST_CLOSE_STALL: assert property (@(posedge clk) disable iff (!rst_n) op_valid && dep_hit && !flush_req |-> !op_ready); // R11

endmodule

// File: tb/vliw_bundle_packer_bench.sv
`timescale 1ns/1ps
module vliw_bundle_packer_bench;

   localparam int LANES = 5;
   localparam int REG_W = 6;
   localparam int PW    = LANES * (1 + 3 + 3 * REG_W) + 1 + 3 * REG_W;
   localparam int QD    = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic op_valid = 1'b0;
   logic op_ready;
   logic [2:0] op_cls = '0;
   logic [REG_W-1:0] op_src_a = '0, op_src_b = '0, op_dst = '0;
   logic bnd_valid;
   logic bnd_ready = 1'b0;
   logic [LANES-1:0] bnd_lane_vld;
   logic [3*LANES-1:0] bnd_lane_cls;
   logic [REG_W*LANES-1:0] bnd_lane_src_a, bnd_lane_src_b, bnd_lane_dst;
   logic bnd_br_vld;
   logic [REG_W-1:0] bnd_br_src_a, bnd_br_src_b, bnd_br_tgt;

   always #4 clk = ~clk;

   vliw_bundle_packer u_vliw_bundle_packer (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .op_valid(op_valid), .op_ready(op_ready), .op_cls(op_cls),
      .op_src_a(op_src_a), .op_src_b(op_src_b), .op_dst(op_dst),
      .bnd_valid(bnd_valid), .bnd_ready(bnd_ready),
      .bnd_lane_vld(bnd_lane_vld), .bnd_lane_cls(bnd_lane_cls),
      .bnd_lane_src_a(bnd_lane_src_a), .bnd_lane_src_b(bnd_lane_src_b),
      .bnd_lane_dst(bnd_lane_dst), .bnd_br_vld(bnd_br_vld),
      .bnd_br_src_a(bnd_br_src_a), .bnd_br_src_b(bnd_br_src_b), .bnd_br_tgt(bnd_br_tgt)
   );

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;
   bit rdy_always = 1'b1;

   logic [PW-1:0] exp_q [QD];
   int wr = 0;
   int rd = 0;

   // reference model of the open bundle
   logic [LANES-1:0]            m_vld;
   logic [LANES-1:0][2:0]       m_cls;
   logic [LANES-1:0][REG_W-1:0] m_a, m_b, m_d;

   task automatic check(input bit ok, input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      m_vld = '0; m_cls = '0; m_a = '0; m_b = '0; m_d = '0;
   endtask

   task automatic model_push(input logic bv, input logic [REG_W-1:0] ba, bb, bt);
      exp_q[wr % QD] = {m_vld, m_cls, m_a, m_b, m_d, bv, ba, bb, bt};
      wr++;
      model_clear();
   endtask

   function automatic logic [LANES-1:0] lane_pick(input logic [2:0] c, input logic [LANES-1:0] occ);
      logic [LANES-1:0] m;
      m = '0;
      if (c == 3'd4) m = occ[4] ? 5'b0 : 5'b10000;
      else if (c == 3'd5) m = (occ[3:0] == 4'b0) ? 5'b01111 : 5'b0;
      else if (c != 3'd6) begin
         for (int i = 0; i < 4; i++) if (!occ[i] && m == '0) m[i] = 1'b1;
         if (m == '0 && !occ[4]) m = 5'b10000;
      end
      return m;
   endfunction

   task automatic model_op(input logic [2:0] c, input logic [REG_W-1:0] a, b, d);
      logic dep;
      logic [LANES-1:0] m;
      dep = 1'b0;
      for (int i = 0; i < LANES; i++) if (m_vld[i] && (m_d[i] == a || m_d[i] == b)) dep = 1'b1;
      m = lane_pick(c, m_vld);
      if (dep || (c != 3'd6 && m == '0)) begin
         model_push(1'b0, '0, '0, '0);
         m = lane_pick(c, m_vld);
      end
      for (int i = 0; i < LANES; i++) if (m[i]) begin
         m_vld[i] = 1'b1; m_cls[i] = c; m_a[i] = a; m_b[i] = b; m_d[i] = d;
      end
      if (c == 3'd6) model_push(1'b1, a, b, d);
      else if (&m_vld) model_push(1'b0, '0, '0, '0);
   endtask

   task automatic send_op(input logic [2:0] c, input logic [REG_W-1:0] a, b, d, input bit expect_stall);
      @(negedge clk);
      op_valid = 1'b1; op_cls = c; op_src_a = a; op_src_b = b; op_dst = d;
      #1;
      if (expect_stall)
         check(op_ready == 1'b0, "R6,R11 op_ready low on closing op", PW'(op_ready), PW'(0));
      while (!op_ready) begin
         @(negedge clk); #1;
      end
      model_op(c, a, b, d);
      @(posedge clk); #1;
      op_valid = 1'b0;
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      if (m_vld != '0) model_push(1'b0, '0, '0, '0);
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // consumer ready
   initial begin
      forever begin
         @(negedge clk);
         bnd_ready = rdy_always ? 1'b1 : ($urandom % 3 != 0);
      end
   end

   // output monitor
   logic [PW-1:0] act_w;
   assign act_w = {bnd_lane_vld, bnd_lane_cls, bnd_lane_src_a, bnd_lane_src_b, bnd_lane_dst,
                   bnd_br_vld, bnd_br_src_a, bnd_br_src_b, bnd_br_tgt};
   localparam int BRW = 1 + 3 * REG_W;

   initial begin
      logic [PW-1:0] held;
      bit stalled;
      stalled = 1'b0;
      held = '0;
      forever begin
         @(negedge clk); #2;
         if (mon_on) begin
            if (stalled)
               check(bnd_valid && act_w == held, "R10 held bundle stable", act_w, held);
            stalled = bnd_valid && !bnd_ready;
            held = act_w;
            if (bnd_valid && bnd_ready) begin
               if (rd >= wr) begin
                  check(1'b0, "R9 unexpected bundle", act_w, '0);
               end else begin
                  check(act_w[PW-1:BRW] == exp_q[rd % QD][PW-1:BRW],
                        "R2,R3,R4,R6,R7,R9 lane contents", act_w, exp_q[rd % QD]);
                  check(act_w[BRW-1:0] == exp_q[rd % QD][BRW-1:0],
                        "R5 branch slot", act_w, exp_q[rd % QD]);
                  rd++;
               end
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_1a7e));
      model_clear();
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      check(bnd_valid == 1'b0 && bnd_lane_vld == '0 && bnd_br_vld == 1'b0,
            "R1 reset state", act_w, '0);
      mon_on = 1'b1;

      // R7: five independent adds fill the bundle
      for (int i = 0; i < 5; i++) send_op(3'd1, 6'(i), 6'(i), 6'(10 + i), 1'b0);
      @(negedge clk); #3;
      check(bnd_valid && bnd_lane_vld == 5'b11111, "R7 full bundle out at once", PW'(bnd_lane_vld), PW'(5'b11111));
      idle(2);

      // R6 and R11: dependent op closes the bundle
      send_op(3'd0, 6'd1, 6'd2, 6'd3, 1'b0);
      send_op(3'd2, 6'd3, 6'd4, 6'd5, 1'b1);
      idle(2);
      do_flush();
      idle(2);

      // R3: two transcendentals
      send_op(3'd4, 6'd1, 6'd1, 6'd20, 1'b0);
      send_op(3'd4, 6'd2, 6'd2, 6'd21, 1'b1);
      // R4: dot after a plain op closes, then add fills lane 4
      do_flush();
      send_op(3'd1, 6'd7, 6'd8, 6'd30, 1'b0);
      send_op(3'd5, 6'd9, 6'd10, 6'd31, 1'b1);
      send_op(3'd3, 6'd11, 6'd12, 6'd32, 1'b0);
      @(negedge clk); #3;
      check(bnd_valid && bnd_lane_vld == 5'b11111, "R4 dot plus top lane", PW'(bnd_lane_vld), PW'(5'b11111));
      idle(2);

      // R5: branch closes its bundle; second branch alone
      send_op(3'd1, 6'd1, 6'd2, 6'd40, 1'b0);
      send_op(3'd6, 6'd3, 6'd4, 6'd50, 1'b0);
      @(negedge clk); #3;
      check(bnd_valid && bnd_br_vld && bnd_lane_vld == 5'b00001, "R5 branch closes bundle",
            PW'({bnd_br_vld, bnd_lane_vld}), PW'(6'b100001));
      send_op(3'd6, 6'd5, 6'd6, 6'd51, 1'b0);
      send_op(3'd0, 6'd1, 6'd2, 6'd41, 1'b0);
      send_op(3'd6, 6'd41, 6'd0, 6'd52, 1'b1);
      idle(3);

      // R8: flush of a partial bundle, then flush of nothing
      send_op(3'd2, 6'd1, 6'd2, 6'd60, 1'b0);
      idle(2);
      do_flush();
      #3;
      check(bnd_valid && bnd_lane_vld == 5'b00001, "R8 flush emits partial", PW'(bnd_lane_vld), PW'(5'b00001));
      idle(2);
      do_flush();
      for (int k = 0; k < 3; k++) begin
         #3;
         check(!bnd_valid, "R8 empty flush emits nothing", PW'(bnd_valid), PW'(0));
         @(negedge clk);
      end

      // random phase with backpressure
      rdy_always = 1'b0;
      for (int n = 0; n < 1500; n++) begin
         int r;
         logic [2:0] c;
         r = $urandom % 100;
         if (r < 50) c = 3'($urandom % 4);
         else if (r < 62) c = 3'd4;
         else if (r < 72) c = 3'd5;
         else if (r < 82) c = 3'd6;
         else if (r < 86) c = 3'd7;
         else c = 3'($urandom % 4);
         send_op(c, 6'($urandom % 14), 6'($urandom % 14), 6'($urandom % 14), 1'b0);
         if ($urandom % 6 == 0) idle(1 + $urandom % 3);
         if ($urandom % 40 == 0) do_flush();
      end
      do_flush();
      rdy_always = 1'b1;
      for (int k = 0; k < 2000 && rd < wr; k++) @(negedge clk);
      idle(3);
      check(rd == wr, "R9 all bundles delivered", PW'(rd), PW'(wr));
      finish_run();
   end

endmodule